// File: doc/BRIEF.md
# Posted Store Buffer with Deferred Bus-Error Reporting

This block sits between the execute stage and the data bus. A store leaves execute as soon as the block takes it into a four-slot queue. The store's bus cycle runs later, in issue order, with at most one cycle in flight. Because the bus cycle is separate from the instruction, a store that ends in a bus error is reported late. The block raises an access-error request that carries whatever program counter execute held when the error response came back, not the address of the store. Nothing the store did is undone.

A barrier request from execute, such as a no-operation used for synchronisation, stalls execute until the queue is empty and no bus cycle is outstanding. An error from any earlier store is therefore visible on the access-error request no later than the cycle in which the barrier is released. If more than one store fails before software acknowledges, the block raises a single request and folds the later failures into a sticky merged flag.

Two state machines hold the control.

The drain machine has three states:
- DR_IDLE: the queue is empty.
- DR_ISSUE: the head entry is presented on the bus.
- DR_WAIT: the block is waiting for the response.

Its transitions are:
- DR_IDLE to DR_ISSUE when the queue is non-empty.
- DR_ISSUE to DR_WAIT on the bus handshake.
- DR_WAIT to DR_ISSUE on a response when more entries are queued.
- DR_WAIT to DR_IDLE on a response when the queue is empty.

The error machine has two states, ER_CLEAR and ER_RAISED. Its transitions are:
- ER_CLEAR to ER_RAISED on an error response.
- ER_RAISED to ER_CLEAR on an acknowledge.
- ER_RAISED stays in ER_RAISED when an acknowledge and an error arrive together, and re-arms with the new PC.

Top module: `wbuf_err_collector`

## Requirements
- R1: A store with `st_valid` high is accepted in that same cycle when fewer than four entries are held. `ex_stall` stays low, and acceptance does not depend on the bus or on a pending exception.
- R2: While four entries are held, a store request drives `ex_stall` high in the same cycle and the store is not taken.
- R3: Entries drain in acceptance order, and `bus_waddr`/`bus_wdata`/`bus_wsize` are held stable while `bus_wvalid` waits for `bus_wready`. After a handshake, `bus_wvalid` stays low until the response (`bus_rsp_valid`) arrives. `bus_wsize` uses the encoding 0 = byte, 1 = halfword, 2 = word.
- R4: A response with `bus_rsp_err` high, arriving while no request is raised, drives `exc_req` high in the next cycle. In that cycle `exc_pc` equals the `ex_pc` seen in the response cycle and `exc_merged` is low.
- R5: An error response arriving while `exc_req` is high, with no acknowledge, sets `exc_merged` in the next cycle. It leaves `exc_pc` unchanged and raises no new request.
- R6: `exc_req` stays high until `exc_ack`. An acknowledge clears `exc_req` and `exc_merged` in the next cycle, unless an error response arrives in that same cycle, in which case the request stays raised with the new PC.
- R7: With `bar_valid` high, `ex_stall` stays high while any entry is queued or a bus cycle is outstanding. It falls in the cycle after the last response.
- R8: When the barrier stall falls, any error from an earlier store is already shown on `exc_req`.
- R9: A barrier with the queue empty and nothing outstanding causes no stall.
- R10: After reset, `bus_wvalid`, `ex_stall`, `exc_req`, `exc_merged` are low and `exc_pc` is zero.
- R11: A response with `bus_rsp_err` low raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request from execute |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_size | input | SIZE_W | Store size (0 byte, 1 halfword, 2 word) |
| bar_valid | input | 1 | Barrier request from execute |
| ex_pc | input | ADDR_W | Current program counter of execute |
| ex_stall | output | 1 | Stall to execute |
| bus_wvalid | output | 1 | Bus write request |
| bus_wready | input | 1 | Bus accepts the write request |
| bus_waddr | output | ADDR_W | Bus write address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_wsize | output | SIZE_W | Bus write size |
| bus_rsp_valid | input | 1 | Bus write completion |
| bus_rsp_err | input | 1 | Completion ended in error |
| exc_req | output | 1 | Access-error exception request |
| exc_pc | output | ADDR_W | PC captured when the error came back |
| exc_merged | output | 1 | A further error was folded into the raised request |
| exc_ack | input | 1 | Exception acknowledged |

## Verification
The results fall due at different times, and each check samples at the cycle its result is due.

| Result | When it is due |
|---|---|
| `ex_stall` for a store or a barrier | Combinational: settles in the cycle of the request |
| `exc_req`, `exc_pc`, `exc_merged` after a response | One edge after the response cycle |
| Acknowledge effect | One edge after the acknowledge |
| Barrier release | The cycle after the final response edge |

How the bench keeps to this:
- Stall is checked a short delay after the falling edge that drives the request, against an occupancy the bench tracks from its own handshake counts.
- Error outputs are checked at the first falling edge after the response edge, against the PC the bench noted while the response was on the bus.
- The bench's bus model holds each response three cycles after the handshake. It checks that no new request appears in that window and that requests arrive in table order.

// File: rtl/iwec_pkg.sv
package iwec_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int SIZE_W = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SIZE_W-1:0] size;
    } wr_entry_t;

    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_ISSUE = 2'd1,
        DR_WAIT  = 2'd2
    } drain_state_t;

    typedef enum logic {
        ER_CLEAR  = 1'b0,
        ER_RAISED = 1'b1
    } err_state_t;
endpackage

// File: rtl/wq_fifo.sv
module wq_fifo
    import iwec_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wr_entry_t push_entry,
    input  logic      pop,
    output wr_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    wr_entry_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (int'(p) == DEPTH - 1) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slots[gi] <= '0;
                end else if (push && (int'(wr_ptr) == gi)) begin
                    slots[gi] <= push_entry;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        head  = slots[rd_ptr];
        full  = (count == CNT_MAX);
        empty = (count == '0);
    end

    // R2: the top never writes into a full queue
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/wq_drain.sv
module wq_drain
    import iwec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  wr_entry_t         q_head,
    output logic              q_pop,
    output logic              drain_idle,
    output logic              bus_wvalid,
    input  logic              bus_wready,
    output logic [ADDR_W-1:0] bus_waddr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [SIZE_W-1:0] bus_wsize,
    input  logic              bus_rsp_valid
);
    drain_state_t state_q;
    drain_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: begin
                if (!q_empty) begin
                    state_d = DR_ISSUE;
                end
            end
            DR_ISSUE: begin
                if (bus_wready) begin
                    state_d = DR_WAIT;
                end
            end
            DR_WAIT: begin
                if (bus_rsp_valid) begin
                    state_d = q_empty ? DR_IDLE : DR_ISSUE;
                end
            end
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        bus_wvalid = (state_q == DR_ISSUE);
        q_pop      = (state_q == DR_ISSUE) && bus_wready;
        drain_idle = (state_q == DR_IDLE);
        bus_waddr  = q_head.addr;
        bus_wdata  = q_head.data;
        bus_wsize  = q_head.size;
    end

    // R3: an offered write holds still until taken
    p_hold_until_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wvalid && !bus_wready |=> bus_wvalid && $stable(bus_waddr)
                                      && $stable(bus_wdata) && $stable(bus_wsize));

    // R3: at most one bus cycle outstanding
    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wvalid && bus_wready |=> !bus_wvalid);
endmodule

// File: rtl/wq_errlog.sv
module wq_errlog
    import iwec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [ADDR_W-1:0] ex_pc,
    input  logic              exc_ack,
    output logic              exc_req,
    output logic [ADDR_W-1:0] exc_pc,
    output logic              exc_merged
);
    err_state_t        state_q;
    err_state_t        state_d;
    logic [ADDR_W-1:0] pc_q;
    logic              merged_q;
    logic              bus_fault;

    always_comb begin
        bus_fault = rsp_valid && rsp_err;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ER_CLEAR: begin
                if (bus_fault) begin
                    state_d = ER_RAISED;
                end
            end
            ER_RAISED: begin
                if (exc_ack && !bus_fault) begin
                    state_d = ER_CLEAR;
                end
            end
            default: state_d = ER_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ER_CLEAR;
            pc_q     <= '0;
            merged_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ER_CLEAR: begin
                    if (bus_fault) begin
                        pc_q     <= ex_pc;
                        merged_q <= 1'b0;
                    end
                end
                ER_RAISED: begin
                    if (exc_ack) begin
                        merged_q <= 1'b0;
                        if (bus_fault) begin
                            pc_q <= ex_pc;
                        end
                    end else if (bus_fault) begin
                        merged_q <= 1'b1;
                    end
                end
                default: merged_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        exc_req    = (state_q == ER_RAISED);
        exc_pc     = pc_q;
        exc_merged = merged_q;
    end

    p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err && !exc_req |=> exc_req && !exc_merged
                                             && (exc_pc == $past(ex_pc)));

    p_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && !exc_ack && rsp_valid && rsp_err |=> exc_req && exc_merged
                                                       && $stable(exc_pc));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && !exc_ack |=> exc_req);

    p_clean_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req && !(rsp_valid && rsp_err) |=> !exc_req);
endmodule

// File: rtl/wbuf_err_collector.sv
module wbuf_err_collector
    import iwec_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              bar_valid,
    input  logic [ADDR_W-1:0] ex_pc,
    output logic              ex_stall,
    output logic              bus_wvalid,
    input  logic              bus_wready,
    output logic [ADDR_W-1:0] bus_waddr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [SIZE_W-1:0] bus_wsize,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_err,
    output logic              exc_req,
    output logic [ADDR_W-1:0] exc_pc,
    output logic              exc_merged,
    input  logic              exc_ack
);
    wr_entry_t new_entry;
    wr_entry_t head;
    logic      q_full;
    logic      q_empty;
    logic      q_push;
    logic      q_pop;
    logic      drain_idle;

    always_comb begin
        new_entry.addr = st_addr;
        new_entry.data = st_data;
        new_entry.size = st_size;
        q_push         = st_valid && !q_full;
        ex_stall       = (st_valid && q_full)
                       || (bar_valid && !(q_empty && drain_idle));
    end

    wq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .push_entry (new_entry),
        .pop        (q_pop),
        .head       (head),
        .full       (q_full),
        .empty      (q_empty)
    );

    wq_drain u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_empty       (q_empty),
        .q_head        (head),
        .q_pop         (q_pop),
        .drain_idle    (drain_idle),
        .bus_wvalid    (bus_wvalid),
        .bus_wready    (bus_wready),
        .bus_waddr     (bus_waddr),
        .bus_wdata     (bus_wdata),
        .bus_wsize     (bus_wsize),
        .bus_rsp_valid (bus_rsp_valid)
    );

    wq_errlog u_errlog (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_valid  (bus_rsp_valid),
        .rsp_err    (bus_rsp_err),
        .ex_pc      (ex_pc),
        .exc_ack    (exc_ack),
        .exc_req    (exc_req),
        .exc_pc     (exc_pc),
        .exc_merged (exc_merged)
    );

    // R7: a released barrier sees a drained queue and an idle bus
    p_barrier_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid && !ex_stall |-> q_empty && drain_idle);

    // R1: a store into a non-full queue is never held back
    p_store_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !bar_valid && !q_full |-> !ex_stall);
endmodule

// File: tb/wbuf_err_collector_bench.sv
module wbuf_err_collector_bench;
    import iwec_pkg::*;

    localparam int DEPTH  = 4;
    localparam int NTAB   = 9;
    localparam int LAT    = 3;
    localparam logic [31:0] T_ADDR [NTAB] = '{32'h1000, 32'h1004, 32'h2008, 32'h100C,
                                              32'h3010, 32'h3014, 32'h4000, 32'h4002,
                                              32'h5000};
    localparam logic [31:0] T_DATA [NTAB] = '{32'hA0A0_0001, 32'hB1B1_0002, 32'hC2C2_0003,
                                              32'hD3D3_0004, 32'hE4E4_0005, 32'hF5F5_0006,
                                              32'h0000_00AA, 32'h0000_BBCC, 32'h1234_5678};
    localparam logic [1:0]  T_SIZE [NTAB] = '{2'd2, 2'd2, 2'd1, 2'd0, 2'd2, 2'd1, 2'd0, 2'd1, 2'd2};
    localparam logic        T_ERR  [NTAB] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic [SIZE_W-1:0] st_size = '0;
    logic              bar_valid = 1'b0;
    logic [ADDR_W-1:0] ex_pc = 32'h100;
    logic              ex_stall;
    logic              bus_wvalid;
    logic              bus_wready = 1'b0;
    logic [ADDR_W-1:0] bus_waddr;
    logic [DATA_W-1:0] bus_wdata;
    logic [SIZE_W-1:0] bus_wsize;
    logic              bus_rsp_valid = 1'b0;
    logic              bus_rsp_err = 1'b0;
    logic              exc_req;
    logic [ADDR_W-1:0] exc_pc;
    logic              exc_merged;
    logic              exc_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int pushed = 0;
    int handed = 0;
    int resp_cnt = 0;
    int ridx = 0;
    bit raised = 1'b0;
    logic [ADDR_W-1:0] first_pc = '0;
    bit done = 1'b0;

    wbuf_err_collector #(.DEPTH(DEPTH)) u_wbuf_err_collector (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_size(st_size), .bar_valid(bar_valid), .ex_pc(ex_pc),
        .ex_stall(ex_stall), .bus_wvalid(bus_wvalid), .bus_wready(bus_wready),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_wsize(bus_wsize),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err), .exc_req(exc_req),
        .exc_pc(exc_pc), .exc_merged(exc_merged), .exc_ack(exc_ack)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // program counter advances once per cycle, away from the falling edge
    initial begin
        forever begin
            @(posedge clk);
            #1 ex_pc <= ex_pc + 32'd4;
        end
    end

    // bus model: take each write at once, answer LAT cycles later (R3, R4, R5, R11)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_wvalid) begin
                chk(bus_waddr == T_ADDR[ridx] && bus_wdata == T_DATA[ridx]
                    && bus_wsize == T_SIZE[ridx], "R3 order",
                    {bus_waddr, bus_wdata}, {T_ADDR[ridx], T_DATA[ridx]});
                bus_wready = 1'b1;
                @(negedge clk);
                bus_wready = 1'b0;
                handed++;
                for (int k = 0; k < LAT - 1; k++) begin
                    chk(!bus_wvalid, "R3 outstanding", 64'(bus_wvalid), 64'd0);
                    @(negedge clk);
                end
                chk(!bus_wvalid, "R3 outstanding", 64'(bus_wvalid), 64'd0);
                begin
                    logic [ADDR_W-1:0] pc_note;
                    bus_rsp_valid = 1'b1;
                    bus_rsp_err   = T_ERR[ridx];
                    pc_note       = ex_pc;
                    @(negedge clk);
                    bus_rsp_valid = 1'b0;
                    bus_rsp_err   = 1'b0;
                    resp_cnt++;
                    if (T_ERR[ridx]) begin
                        if (!raised) begin
                            chk(exc_req && !exc_merged && exc_pc == pc_note, "R4",
                                {31'd0, exc_req, exc_pc}, {32'd1, pc_note});
                            raised   = 1'b1;
                            first_pc = pc_note;
                        end else begin
                            chk(exc_req && exc_merged && exc_pc == first_pc, "R5",
                                {30'd0, exc_req, exc_merged, exc_pc}, {32'd3, first_pc});
                        end
                    end else begin
                        chk(exc_req == raised, "R11", 64'(exc_req), 64'(raised));
                    end
                    ridx++;
                end
            end
        end
    end

    task automatic push(input int i);
        bit exp_full;
        @(negedge clk);
        st_valid = 1'b1;
        st_addr  = T_ADDR[i];
        st_data  = T_DATA[i];
        st_size  = T_SIZE[i];
        #2;
        exp_full = (pushed - handed) >= DEPTH;
        chk(ex_stall == exp_full, exp_full ? "R2" : "R1", 64'(ex_stall), 64'(exp_full));
        while (ex_stall) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        pushed++;
    endtask

    task automatic barrier_wait(output int stall_cycles);
        stall_cycles = 0;
        @(negedge clk);
        bar_valid = 1'b1;
        #2;
        while (ex_stall) begin
            stall_cycles++;
            @(negedge clk);
            #2;
        end
    endtask

    initial begin
        int sc;
        repeat (3) @(negedge clk);
        chk(!bus_wvalid && !ex_stall && !exc_req && !exc_merged && exc_pc == '0, "R10",
            {bus_wvalid, ex_stall, exc_req, exc_merged}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!bus_wvalid && !ex_stall && !exc_req, "R10", {bus_wvalid, ex_stall, exc_req}, 0);

        // table walk: eight stores, faults on entries 2 and 5
        for (int i = 0; i < NTAB - 1; i++) begin
            push(i);
        end
        @(negedge clk);
        st_valid = 1'b0;

        barrier_wait(sc);
        chk(sc > 0, "R7 stalled", sc, 1);
        chk(resp_cnt == NTAB - 1, "R7 drained", resp_cnt, NTAB - 1);
        chk(exc_req && exc_merged, "R8", {exc_req, exc_merged}, 2'b11);
        @(negedge clk);
        bar_valid = 1'b0;

        // acknowledge
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
        raised  = 1'b0;
        chk(!exc_req && !exc_merged, "R6", {exc_req, exc_merged}, 0);

        // barrier on an empty buffer
        barrier_wait(sc);
        chk(sc == 0, "R9", sc, 0);
        @(negedge clk);
        bar_valid = 1'b0;

        // single fresh fault after acknowledge, collected by a barrier
        push(NTAB - 1);
        @(negedge clk);
        st_valid = 1'b0;
        barrier_wait(sc);
        chk(resp_cnt == NTAB && sc > 0, "R7", resp_cnt, NTAB);
        chk(exc_req && !exc_merged, "R8", {exc_req, exc_merged}, 2'b10);
        @(negedge clk);
        bar_valid = 1'b0;
        chk(exc_req, "R6 held", 64'(exc_req), 64'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule